// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves data hazards for a five-stage in-order integer pipeline. Each cycle it compares the source register numbers of the instruction in the execute stage with the destinations of the two older instructions still in flight, in the memory and write-back stages. For each of the two ALU operands it produces a select code that chooses the register-file value, the memory-stage result or the write-back-stage result.

A register-number match alone cannot cover one case: a load in execute whose destination is read by the instruction in decode. The loaded data does not exist yet, so the unit asserts a stall. The stall holds the fetch address and the fetch/decode register. In the same cycle a bubble-insert strobe turns the execute-stage entry into a no-op. Older instructions keep moving, so the stall lasts exactly one cycle. After that cycle the loaded value reaches the consumer through the write-back forwarding path.

The block also holds the architectural register file. It has two combinational read ports, used by decode, and one write port, driven by write-back. A read of the register being written in the same cycle returns the new value.

Top module: `fwd_hazard_top`

## Requirements
- R1: When `memRegWrite` is 1, `memRd` is nonzero and `memRd` equals an execute source, that operand's select is 2'b10.
- R2: When R1 does not apply to an operand, `wbRegWrite` is 1, `wbRd` is nonzero and `wbRd` equals that execute source, that operand's select is 2'b01.
- R3: When the memory-stage and write-back-stage destinations both match a source, the memory-stage result wins and the select is 2'b10.
- R4: Otherwise the select is 2'b00, the register-file value. A stage whose write-enable is 0 never causes forwarding.
- R5: Register number 0 never causes forwarding or a stall, whatever the write-enables are.
- R6: `stallFront` and `bubbleEx` are both 1 in the same cycle exactly when `exIsLoad` is 1, `exRd` is nonzero and `exRd` equals `idRs1` or `idRs2`.
- R7: An instruction in execute that is not a load never causes a stall, even when its destination matches a decode source.
- R8: When `wbRegWrite` is 1 and `wbRd` is nonzero, `wbData` is stored at the rising clock edge. Later reads of that register return it.
- R9: A decode read of the register being written in the same cycle returns `wbData`.
- R10: Register 0 always reads as zero. Writes to it are ignored.
- R11: While `rstN` is low, every register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idRs1 | input | AW | First source register number of the instruction in decode |
| idRs2 | input | AW | Second source register number of the instruction in decode |
| exRs1 | input | AW | First source register number of the instruction in execute |
| exRs2 | input | AW | Second source register number of the instruction in execute |
| exRd | input | AW | Destination register number of the instruction in execute |
| exIsLoad | input | 1 | The instruction in execute is a load |
| memRd | input | AW | Destination register number in the memory stage |
| memRegWrite | input | 1 | The memory-stage instruction writes a register |
| wbRd | input | AW | Destination register number in the write-back stage |
| wbRegWrite | input | 1 | The write-back-stage instruction writes a register |
| wbData | input | XLEN | Write-back result |
| fwdSelA | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back stage |
| fwdSelB | output | 2 | Operand B select, same encoding |
| stallFront | output | 1 | Hold the fetch address and the fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into the execute-stage register (all write-enables cleared) |
| rdData1 | output | XLEN | Register-file read data for `idRs1` |
| rdData2 | output | XLEN | Register-file read data for `idRs2` |

## Verification
The bench builds the block with XLEN = 16 and REG_COUNT = 8, so AW is 3. With only eight register numbers, random draws often produce matches. That makes double matches in the memory and write-back stages, load-use collisions and write/read collisions on the same register frequent, and every one of them is compared with the bench's own model. Directed sequences cover the remaining cases. One replays a result consumed by the four following instructions, covering the memory-stage path, the write-back path, the same-cycle read and a plain read of the stored value. Another replays a load followed by a dependent store, checking the single stall cycle and the forwarding after it. Register 0 is exercised as a destination, as a source and as a write target.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_WB    = 2'b01,
    SEL_MEM   = 2'b10,
    SEL_UNUSED = 2'b11
  } opSel_t;

  typedef struct packed {
    logic   stallFront;
    logic   bubbleEx;
    opSel_t selA;
    opSel_t selB;
  } hzStrobes_t;
endpackage

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import fwd_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [AW-1:0] exRs1,
  input  logic [AW-1:0] exRs2,
  input  logic [AW-1:0] exRd,
  input  logic          exIsLoad,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  output hzStrobes_t    strobes
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][AW-1:0] exSrc;
  logic [NUM_OPS-1:0][AW-1:0] idSrc;
  opSel_t [NUM_OPS-1:0]       opSel;
  logic [NUM_OPS-1:0]         loadHit;

  logic memLive;
  logic wbLive;
  logic loadLive;

  assign exSrc    = {exRs2, exRs1};
  assign idSrc    = {idRs2, idRs1};
  assign memLive  = memRegWrite && (memRd != '0);
  assign wbLive   = wbRegWrite && (wbRd != '0);
  assign loadLive = exIsLoad && (exRd != '0);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic memHit;
    logic wbHit;

    assign memHit     = memLive && (memRd == exSrc[i]);
    assign wbHit      = wbLive && (wbRd == exSrc[i]);
    assign loadHit[i] = loadLive && (exRd == idSrc[i]);

    always_comb begin
      if (memHit)     opSel[i] = SEL_MEM;
      else if (wbHit) opSel[i] = SEL_WB;
      else            opSel[i] = SEL_RF;
    end

    a_r3_younger_wins: assert property (@(posedge clk) disable iff (!rstN)
      (memRegWrite && wbRegWrite && memRd == wbRd && memRd == exSrc[i] && exSrc[i] != '0)
        |-> opSel[i] == SEL_MEM);

    a_r5_zero_no_forward: assert property (@(posedge clk) disable iff (!rstN)
      (exSrc[i] == '0) |-> opSel[i] == SEL_RF);

    a_r4_disabled_no_forward: assert property (@(posedge clk) disable iff (!rstN)
      (!memRegWrite && !wbRegWrite) |-> opSel[i] == SEL_RF);
  end

  always_comb begin
    strobes.stallFront = |loadHit;
    strobes.bubbleEx   = |loadHit;
    strobes.selA       = opSel[0];
    strobes.selB       = opSel[1];
  end

  a_r6_stall_with_bubble: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stallFront == strobes.bubbleEx);

  a_r7_nonload_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !exIsLoad |-> !strobes.stallFront);

  a_r5_zero_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0) |-> !strobes.stallFront);
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  parameter int AW        = $clog2(REG_COUNT)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0][AW-1:0]         rdAddr,
  output logic [1:0][XLEN-1:0]       rdData,
  input  logic                       wrEn,
  input  logic [AW-1:0]              wrAddr,
  input  logic [XLEN-1:0]            wrData
);
  localparam int NUM_RD = 2;

  logic [XLEN-1:0] regs [REG_COUNT];
  logic            wrLive;

  assign wrLive = wrEn && (wrAddr != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REG_COUNT; r++) regs[r] <= '0;
    end else if (wrLive) begin
      regs[wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rdAddr[p] == '0)                      rdData[p] = '0;
      else if (wrLive && wrAddr == rdAddr[p])   rdData[p] = wrData;
      else                                      rdData[p] = regs[rdAddr[p]];
    end

    a_r8_write_sticks: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr != '0) |=>
        (!(rdAddr[p] == $past(wrAddr) && !(wrEn && wrAddr == $past(wrAddr)))
         || rdData[p] == $past(wrData)));

    a_r10_zero_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[p] == '0) |-> rdData[p] == '0);
  end
endmodule

// File: rtl/fwd_hazard_top.sv
module fwd_hazard_top
  import fwd_hazard_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  parameter int AW        = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   idRs1,
  input  logic [AW-1:0]   idRs2,
  input  logic [AW-1:0]   exRs1,
  input  logic [AW-1:0]   exRs2,
  input  logic [AW-1:0]   exRd,
  input  logic            exIsLoad,
  input  logic [AW-1:0]   memRd,
  input  logic            memRegWrite,
  input  logic [AW-1:0]   wbRd,
  input  logic            wbRegWrite,
  input  logic [XLEN-1:0] wbData,
  output logic [1:0]      fwdSelA,
  output logic [1:0]      fwdSelB,
  output logic            stallFront,
  output logic            bubbleEx,
  output logic [XLEN-1:0] rdData1,
  output logic [XLEN-1:0] rdData2
);
  hzStrobes_t            strobes;
  logic [1:0][XLEN-1:0]  rdBus;

  hz_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .idRs1(idRs1), .idRs2(idRs2),
    .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exIsLoad(exIsLoad),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .strobes(strobes)
  );

  hz_regfile #(.XLEN(XLEN), .REG_COUNT(REG_COUNT), .AW(AW)) u_rf (
    .clk(clk), .rstN(rstN),
    .rdAddr({idRs2, idRs1}),
    .rdData(rdBus),
    .wrEn(wbRegWrite), .wrAddr(wbRd), .wrData(wbData)
  );

  assign fwdSelA    = strobes.selA;
  assign fwdSelB    = strobes.selB;
  assign stallFront = strobes.stallFront;
  assign bubbleEx   = strobes.bubbleEx;
  assign rdData1    = rdBus[0];
  assign rdData2    = rdBus[1];
endmodule

// File: tb/fwd_hazard_top_test.sv
module fwd_hazard_top_test;
  localparam int XLEN = 16;
  localparam int REG_COUNT = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exIsLoad, memRegWrite, wbRegWrite;
  logic [XLEN-1:0] wbData;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallFront, bubbleEx;
  logic [XLEN-1:0] rdData1, rdData2;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] model [REG_COUNT];

  always #10 clk = ~clk;

  fwd_hazard_top #(.XLEN(XLEN), .REG_COUNT(REG_COUNT), .AW(AW)) uut (
    .clk(clk), .rstN(rstN),
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exIsLoad(exIsLoad), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .wbData(wbData),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .stallFront(stallFront),
    .bubbleEx(bubbleEx), .rdData1(rdData1), .rdData2(rdData2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(input logic [AW-1:0] src);
    if (src != 0 && memRegWrite && memRd == src) return 2'b10;
    if (src != 0 && wbRegWrite && wbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expStall();
    return exIsLoad && exRd != 0 && (exRd == idRs1 || exRd == idRs2);
  endfunction

  function automatic logic [XLEN-1:0] expRead(input logic [AW-1:0] a);
    if (a == 0) return '0;
    if (wbRegWrite && wbRd == a) return wbData;
    return model[a];
  endfunction

  task automatic clr();
    idRs1 = 0; idRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; exIsLoad = 0;
    memRd = 0; memRegWrite = 0; wbRd = 0; wbRegWrite = 0; wbData = 0;
  endtask

  // commit the bench model at the coming edge, then move to the next drive point
  task automatic stepEdge();
    if (wbRegWrite && wbRd != 0) model[wbRd] = wbData;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < REG_COUNT; r++) model[r] = '0;
    clr();
    // R11: the write port is enabled during reset and must not take effect
    wbRegWrite = 1; wbRd = 3; wbData = 16'hbeef;
    repeat (3) @(negedge clk);
    wbRegWrite = 0;
    for (int r = 0; r < REG_COUNT; r++) begin
      idRs1 = AW'(r); #2;
      chk("R11 reset clears register", rdData1, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // a producer feeding its four followers: cycle with producer in the memory stage
    clr(); memRd = 1; memRegWrite = 1; exRs1 = 1; exRs2 = 5; exRd = 4; idRs1 = 1; #2;
    chk("R1 memory-stage forward A", fwdSelA, 2'b10);
    chk("R4 unrelated operand B", fwdSelB, 2'b00);
    chk("R7 non-load never stalls", stallFront, 0);
    stepEdge();
    // producer in write-back: second follower in execute, third in decode
    clr(); memRd = 4; memRegWrite = 1; wbRd = 1; wbRegWrite = 1; wbData = 16'h1234;
    exRs1 = 1; exRs2 = 6; idRs1 = 1; #2;
    chk("R2 write-back forward A", fwdSelA, 2'b01);
    chk("R9 same-cycle read returns new value", rdData1, 16'h1234);
    stepEdge();
    // fourth follower reads the stored value
    clr(); exRs1 = 1; idRs2 = 1; #2;
    chk("R4 no in-flight producer", fwdSelA, 2'b00);
    chk("R8 stored value read back", rdData2, 16'h1234);

    // priority with both stages matching
    clr(); memRd = 2; memRegWrite = 1; wbRd = 2; wbRegWrite = 1; wbData = 16'h0002; exRs2 = 2; #2;
    chk("R3 memory stage wins", fwdSelB, 2'b10);
    stepEdge();
    clr(); memRd = 3; exRs1 = 3; wbRd = 3; #2;
    chk("R4 write-enables low block forwarding", fwdSelA, 2'b00);
    clr(); memRegWrite = 1; wbRegWrite = 1; wbData = 16'h00ff; exRs1 = 0; exRs2 = 0; #2;
    chk("R5 register 0 never forwards A", fwdSelA, 2'b00);
    chk("R5 register 0 never forwards B", fwdSelB, 2'b00);
    chk("R10 register 0 reads zero under write", rdData1, 0);
    stepEdge();
    clr(); #2;
    chk("R10 register 0 write ignored", rdData1, 0);
    clr(); exIsLoad = 1; exRd = 0; #2;
    chk("R5 register 0 load never stalls", stallFront, 0);

    // load then dependent store
    clr(); exIsLoad = 1; exRd = 4; idRs1 = 1; idRs2 = 4; #2;
    chk("R6 load-use stall", stallFront, 1);
    chk("R6 load-use bubble", bubbleEx, 1);
    stepEdge();
    clr(); memRd = 4; memRegWrite = 1; idRs1 = 1; idRs2 = 4; #2;
    chk("R6 stall lasts one cycle", stallFront, 0);
    stepEdge();
    clr(); wbRd = 4; wbRegWrite = 1; wbData = 16'h5a5a; exRs1 = 1; exRs2 = 4; #2;
    chk("R2 loaded value forwarded to store data", fwdSelB, 2'b01);
    chk("R4 base operand from register file", fwdSelA, 2'b00);
    stepEdge();
    clr(); exIsLoad = 1; exRd = 4; idRs1 = 1; idRs2 = 2; #2;
    chk("R6 independent follower no stall", stallFront, 0);
    clr(); exRd = 5; idRs1 = 5; #2;
    chk("R7 non-load producer no stall", stallFront, 0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      idRs1 = AW'($urandom); idRs2 = AW'($urandom);
      exRs1 = AW'($urandom); exRs2 = AW'($urandom); exRd = AW'($urandom);
      exIsLoad = 1'($urandom); memRd = AW'($urandom); memRegWrite = 1'($urandom);
      wbRd = AW'($urandom); wbRegWrite = 1'($urandom); wbData = XLEN'($urandom);
      #2;
      chk("R1 R2 R3 random select A", fwdSelA, expSel(exRs1));
      chk("R1 R2 R3 random select B", fwdSelB, expSel(exRs2));
      chk("R6 random stall", stallFront, expStall());
      chk("R6 random bubble", bubbleEx, expStall());
      chk("R8 R9 random read 1", rdData1, expRead(idRs1));
      chk("R8 R9 random read 2", rdData2, expRead(idRs2));
      stepEdge();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule